// File: doc/BRIEF.md
# EEPROM Page Load Buffer and Byte Pointer

This block sits behind a serial-bus target front end and owns the nonvolatile side of a two-bank serial memory. Each bank is 256 bytes, arranged as 16 pages of 16 bytes. The front end gives the block decoded events: a byte-address load, data-byte strobes, read-advance strobes and the STOP that ends a transaction. It also supplies the active bank bit from an external register, and one write-inhibit flag for each half of each bank. The block keeps a single byte pointer and collects written bytes in a 16-entry page buffer with a per-slot valid mask. After STOP it writes the loaded slots into an on-chip storage array, one slot per clock, through a visible write port.

Cell programming time is modelled by a cycle counter. While this counter runs, the busy flag is high. During that time every strobe from the front end is refused, so the front end can use the flag to withhold its acknowledge. Read data always shows the array byte at the pointer in the active bank.

Top module: `eepg_core`

## Requirements
- R1: After reset the pointer is 00h, every byte of both banks reads 0xFF, busy is low and the write port is idle.
- R2: An address load (accepted when not busy) sets the pointer to `addr_i`. `rd_data_o` shows the array byte at address {bank_i, pointer}.
- R3: Each accepted read-advance adds one to the full 8-bit pointer. From FFh it goes to 00h of the same active bank.
- R4: Each accepted data byte goes into buffer slot pointer[3:0] and marks that slot valid. Then pointer[3:0] advances modulo 16 and pointer[7:4] is unchanged.
- R5: When more than 16 bytes are sent in one transaction, the slot index wraps and a later byte replaces the earlier byte in that slot.
- R6: The array does not change before STOP. After the commit, only the slots loaded since the last address load have changed, at {bank at STOP, pointer[7:4], slot}.
- R7: A committing STOP raises busy on the next clock. Busy then stays high for exactly WRITE_CYCLES clocks.
- R8: While busy, address loads, data bytes, read-advances and STOP have no effect on the pointer, the buffer or the array.
- R9: A STOP that has no data byte loaded since the address load commits nothing and leaves busy low.
- R10: When wr_inhibit_i[{bank_i, pointer[7]}] is set at STOP, nothing is committed, busy stays low and the loaded bytes are discarded.
- R11: The bank bit selects the bank for reads. The bank value sampled at STOP selects the bank that the commit writes.
- R12: During a commit, mem_we_o pulses once for each valid slot, in slot order, with mem_addr_o = {bank, page, slot} and the buffered byte on mem_wdata_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_i | input | BANK_W | Active bank select |
| wr_inhibit_i | input | NUM_BANKS*2 | Write inhibit per half bank, index {bank, addr[7]} |
| addr_load_i | input | 1 | Load pointer from addr_i, clear valid mask |
| addr_i | input | PTR_W | Byte address |
| wr_byte_i | input | 1 | Data byte strobe |
| wr_data_i | input | BYTE_W | Data byte |
| rd_adv_i | input | 1 | Read byte sent, advance pointer |
| stop_i | input | 1 | STOP seen, start commit |
| rd_data_o | output | BYTE_W | Array byte at {bank_i, pointer} |
| busy_o | output | 1 | Internal write cycle running |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | BANK_W+PTR_W | Array write address |
| mem_wdata_o | output | BYTE_W | Array write data |

## Verification
The bench sends 18 bytes into one page. A design that does not wrap the slot index, or that lets the early bytes win, reads back the wrong values at the first two slots. It advances reads from FFh in the upper bank. A pointer that carries into the bank bit, or that stops at the top of the bank, returns the lower bank's byte or FFh. It fires strobes and a second STOP while busy is high. A design that does not gate them moves the pointer or starts a phantom commit. Address-only transactions and transactions into an inhibited half check that busy never rises and that the discarded bytes never reach the array later.

// File: rtl/eepg_pkg.sv
package eepg_pkg;
  localparam int unsigned EEPG_BYTE_W = 8;
  localparam int unsigned EEPG_PTR_W  = 8;
  localparam int unsigned EEPG_SLOT_W = 4;
  localparam logic [EEPG_BYTE_W-1:0] EEPG_ERASED = '1;
endpackage

// File: rtl/eepg_ptr.sv
module eepg_ptr #(
  parameter int unsigned PTR_W  = eepg_pkg::EEPG_PTR_W,
  parameter int unsigned SLOT_W = eepg_pkg::EEPG_SLOT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [PTR_W-1:0] addr_i,
  input  logic             wr_i,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ptr_q <= '0;
    else if (en_i) begin
      if (load_i)                ptr_q <= addr_i;
      else if (wr_i)             ptr_q <= {ptr_q[PTR_W-1:SLOT_W], ptr_q[SLOT_W-1:0] + 1'b1};
      else if (adv_i)            ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr_o = ptr_q;

  assert_rd_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i && !wr_i && adv_i && (ptr_q == '1) |=> ptr_q == '0);
  assert_page_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i && wr_i |=> ptr_q[PTR_W-1:SLOT_W] == $past(ptr_q[PTR_W-1:SLOT_W]));
  assert_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(ptr_q));
endmodule

// File: rtl/eepg_pagebuf.sv
module eepg_pagebuf #(
  parameter int unsigned SLOT_W = eepg_pkg::EEPG_SLOT_W,
  parameter int unsigned BYTE_W = eepg_pkg::EEPG_BYTE_W,
  localparam int unsigned SLOTS = 1 << SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  output logic              any_vld_o
);
  logic [BYTE_W-1:0] slot_q [SLOTS];
  logic [SLOTS-1:0]  vld_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[g] <= '0;
        vld_q[g]  <= 1'b0;
      end else if (clr_i) begin
        vld_q[g]  <= 1'b0;
      end else if (wr_i && (wr_slot_i == SLOT_W'(g))) begin
        slot_q[g] <= wr_data_i;   // later byte overwrites on wrap
        vld_q[g]  <= 1'b1;
      end
    end
  end

  assign rd_data_o = slot_q[rd_slot_i];
  assign rd_vld_o  = vld_q[rd_slot_i];
  assign any_vld_o = |vld_q;

  assert_load_marks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !clr_i |=> any_vld_o);
  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !any_vld_o);
endmodule

// File: rtl/eepg_commit.sv
module eepg_commit #(
  parameter int unsigned WRITE_CYCLES = 40,
  parameter int unsigned SLOT_W       = eepg_pkg::EEPG_SLOT_W,
  parameter int unsigned PTR_W        = eepg_pkg::EEPG_PTR_W,
  parameter int unsigned BANK_W       = 1,
  localparam int unsigned PAGE_W      = PTR_W - SLOT_W,
  localparam int unsigned SLOTS       = 1 << SLOT_W,
  localparam int unsigned BLK_W       = BANK_W + 1,
  localparam int unsigned CNT_W       = $clog2(WRITE_CYCLES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    stop_i,
  input  logic                    any_vld_i,
  input  logic [BANK_W-1:0]       bank_i,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic [(1<<BLK_W)-1:0]   inhibit_i,
  input  logic                    slot_vld_i,
  output logic [SLOT_W-1:0]       scan_slot_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    drop_o,
  output logic                    we_o,
  output logic [BANK_W+PTR_W-1:0] addr_o
);
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BANK_W-1:0] bank_q;
  logic [PAGE_W-1:0] page_q;
  logic [BLK_W-1:0]  blk;
  logic              start;

  assign blk    = {bank_i, page_i[PAGE_W-1]};
  assign start  = stop_i && !busy_q && any_vld_i && !inhibit_i[blk];
  assign drop_o = stop_i && !busy_q && !start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      bank_q <= '0;
      page_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      bank_q <= bank_i;
      page_q <= page_i;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(WRITE_CYCLES - 1)) busy_q <= 1'b0;
      else                                   cnt_q  <= cnt_q + 1'b1;
    end
  end

  // first SLOTS cycles of the timer scan the buffer
  assign scan_slot_o = cnt_q[SLOT_W-1:0];
  assign we_o        = busy_q && (cnt_q < CNT_W'(SLOTS)) && slot_vld_i;
  assign addr_o      = {bank_q, page_q, cnt_q[SLOT_W-1:0]};
  assign done_o      = busy_q && (cnt_q == CNT_W'(WRITE_CYCLES - 1));
  assign busy_o      = busy_q;

  initial assert_cfg_R7: assert (WRITE_CYCLES >= SLOTS);

  assert_busy_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(cnt_q) == CNT_W'(WRITE_CYCLES - 1));
  assert_empty_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !busy_q && !any_vld_i |=> !busy_q);
  assert_inhibit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !busy_q && inhibit_i[blk] |=> !busy_q);
endmodule

// File: rtl/eepg_core.sv
module eepg_core #(
  parameter int unsigned WRITE_CYCLES = 40,
  parameter int unsigned NUM_BANKS    = 2,
  parameter int unsigned PTR_W        = eepg_pkg::EEPG_PTR_W,
  parameter int unsigned SLOT_W       = eepg_pkg::EEPG_SLOT_W,
  parameter int unsigned BYTE_W       = eepg_pkg::EEPG_BYTE_W,
  localparam int unsigned BANK_W      = $clog2(NUM_BANKS),
  localparam int unsigned MEM_AW      = BANK_W + PTR_W,
  localparam int unsigned MEM_DEPTH   = 1 << MEM_AW,
  localparam int unsigned PAGE_W      = PTR_W - SLOT_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [BANK_W-1:0]      bank_i,
  input  logic [NUM_BANKS*2-1:0] wr_inhibit_i,
  input  logic                   addr_load_i,
  input  logic [PTR_W-1:0]       addr_i,
  input  logic                   wr_byte_i,
  input  logic [BYTE_W-1:0]      wr_data_i,
  input  logic                   rd_adv_i,
  input  logic                   stop_i,
  output logic [BYTE_W-1:0]      rd_data_o,
  output logic                   busy_o,
  output logic                   mem_we_o,
  output logic [MEM_AW-1:0]      mem_addr_o,
  output logic [BYTE_W-1:0]      mem_wdata_o
);
  logic [PTR_W-1:0]  ptr;
  logic              busy, done, drop, any_vld, slot_vld, buf_wr, buf_clr;
  logic [SLOT_W-1:0] scan_slot;
  logic [BYTE_W-1:0] mem_q [MEM_DEPTH];
  logic [(1<<(BANK_W+1))-1:0] inhibit;

  assign inhibit = (1<<(BANK_W+1))'(wr_inhibit_i);
  assign buf_wr  = wr_byte_i && !busy && !addr_load_i;
  assign buf_clr = (addr_load_i && !busy) || done || drop;

  eepg_ptr #(.PTR_W(PTR_W), .SLOT_W(SLOT_W)) u_ptr (
    .clk_i, .rst_ni, .en_i(!busy), .load_i(addr_load_i), .addr_i,
    .wr_i(wr_byte_i), .adv_i(rd_adv_i), .ptr_o(ptr)
  );

  eepg_pagebuf #(.SLOT_W(SLOT_W), .BYTE_W(BYTE_W)) u_buf (
    .clk_i, .rst_ni, .clr_i(buf_clr), .wr_i(buf_wr), .wr_slot_i(ptr[SLOT_W-1:0]),
    .wr_data_i, .rd_slot_i(scan_slot), .rd_data_o(mem_wdata_o),
    .rd_vld_o(slot_vld), .any_vld_o(any_vld)
  );

  eepg_commit #(.WRITE_CYCLES(WRITE_CYCLES), .SLOT_W(SLOT_W), .PTR_W(PTR_W),
                .BANK_W(BANK_W)) u_commit (
    .clk_i, .rst_ni, .stop_i, .any_vld_i(any_vld), .bank_i,
    .page_i(ptr[PTR_W-1:SLOT_W]), .inhibit_i(inhibit), .slot_vld_i(slot_vld),
    .scan_slot_o(scan_slot), .busy_o(busy), .done_o(done), .drop_o(drop),
    .we_o(mem_we_o), .addr_o(mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(MEM_DEPTH); i++) mem_q[i] <= eepg_pkg::EEPG_ERASED;
    end else if (mem_we_o) begin
      mem_q[mem_addr_o] <= mem_wdata_o;
    end
  end

  assign rd_data_o = mem_q[{bank_i, ptr}];
  assign busy_o    = busy;

  assert_quiet_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
  assert_page_match_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && $past(mem_we_o) |-> mem_addr_o[MEM_AW-1:SLOT_W] == $past(mem_addr_o[MEM_AW-1:SLOT_W]));
  assert_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));
endmodule

// File: tb/eepg_core_test.sv
module eepg_core_test;
  localparam int WC = 20;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bank = 1'b0;
  logic [3:0] inh = '0;
  logic       ld = 0, wr = 0, adv = 0, stp = 0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rd_data, mem_wdata;
  logic       busy, mem_we;
  logic [8:0] mem_addr;

  int n_chk = 0, n_fail = 0;
  int we_cnt = 0;
  logic [8:0] first_addr;
  logic [7:0] first_data;
  logic [7:0] model [512];

  always #2.5 clk = ~clk;

  eepg_core #(.WRITE_CYCLES(WC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bank_i(bank), .wr_inhibit_i(inh),
    .addr_load_i(ld), .addr_i(addr), .wr_byte_i(wr), .wr_data_i(wdata),
    .rd_adv_i(adv), .stop_i(stp), .rd_data_o(rd_data), .busy_o(busy),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  always @(negedge clk) if (rst_n && mem_we) begin
    if (we_cnt == 0) begin first_addr = mem_addr; first_data = mem_wdata; end
    we_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_ld(input logic [7:0] a);
    @(negedge clk); ld = 1; addr = a; @(negedge clk); ld = 0;
  endtask
  task automatic pulse_wr(input logic [7:0] d);
    @(negedge clk); wr = 1; wdata = d; @(negedge clk); wr = 0;
  endtask
  task automatic pulse_adv();
    @(negedge clk); adv = 1; @(negedge clk); adv = 0;
  endtask
  // STOP, then count busy cycles until idle
  task automatic stop_wait(output int nb);
    @(negedge clk); stp = 1; @(negedge clk); stp = 0;
    nb = 0;
    while (busy && nb < 1000) begin nb++; @(negedge clk); end
  endtask

  task automatic t_reset();
    check(busy == 0, "R1 busy", busy, 0);
    check(rd_data == 8'hFF, "R1 erased", rd_data, 8'hFF);
    check(mem_we == 0, "R1 port idle", mem_we, 0);
  endtask

  task automatic t_write_page();
    int nb;
    bank = 0; we_cnt = 0;
    pulse_ld(8'h35);
    pulse_wr(8'hA1); pulse_wr(8'hA2); pulse_wr(8'hA3);
    check(we_cnt == 0, "R6 no write before stop", we_cnt, 0);
    stop_wait(nb);
    model[9'h035] = 8'hA1; model[9'h036] = 8'hA2; model[9'h037] = 8'hA3;
    check(nb == WC, "R7 busy length", nb, WC);
    check(we_cnt == 3, "R12 write strobes", we_cnt, 3);
    check(first_addr == 9'h035 && first_data == 8'hA1, "R12 first write", {first_addr, first_data}, {9'h035, 8'hA1});
    pulse_ld(8'h35);
    check(rd_data == 8'hA1, "R2 load", rd_data, 8'hA1);
    pulse_adv(); check(rd_data == 8'hA2, "R3 adv", rd_data, 8'hA2);
    pulse_adv(); check(rd_data == 8'hA3, "R3 adv", rd_data, 8'hA3);
    pulse_adv(); check(rd_data == 8'hFF, "R6 untouched neighbour", rd_data, 8'hFF);
    pulse_ld(8'h34); check(rd_data == 8'hFF, "R6 untouched below", rd_data, 8'hFF);
  endtask

  task automatic t_wrap_page();
    int nb;
    bank = 0; we_cnt = 0;
    pulse_ld(8'h4E);
    for (int i = 0; i < 18; i++) begin
      pulse_wr(8'(8'h10 + i));
      model[9'h040 + ((14 + i) % 16)] = 8'(8'h10 + i);
    end
    stop_wait(nb);
    check(we_cnt == 16, "R5 full page strobes", we_cnt, 16);
    pulse_ld(8'h40);
    for (int s = 0; s < 16; s++) begin
      check(rd_data == model[9'h040 + s], "R5 wrap overwrite", rd_data, model[9'h040 + s]);
      pulse_adv();
    end
    check(rd_data == 8'hFF, "R4 page stays put", rd_data, 8'hFF);
  endtask

  task automatic t_empty();
    int nb;
    we_cnt = 0;
    pulse_ld(8'h60);
    stop_wait(nb);
    repeat (3) @(negedge clk);
    check(nb == 0 && busy == 0, "R9 no busy", nb, 0);
    check(we_cnt == 0, "R9 no write", we_cnt, 0);
  endtask

  task automatic t_busy_ignore();
    int nb;
    bank = 0;
    pulse_ld(8'h20);
    for (int i = 0; i < 16; i++) begin
      pulse_wr(8'(8'hC0 + i));
      model[9'h020 + i] = 8'(8'hC0 + i);
    end
    @(negedge clk); stp = 1; @(negedge clk); stp = 0;
    pulse_ld(8'h25); pulse_adv(); pulse_wr(8'h77);
    @(negedge clk); stp = 1; @(negedge clk); stp = 0;
    check(busy == 1, "R7 still busy", busy, 1);
    nb = 0;
    while (busy && nb < 1000) begin nb++; @(negedge clk); end
    check(rd_data == 8'hC0, "R8 pointer frozen", rd_data, 8'hC0);
    we_cnt = 0;
    stop_wait(nb);
    check(nb == 0 && we_cnt == 0, "R8 byte ignored while busy", nb, 0);
    pulse_ld(8'h22); check(rd_data == 8'hC2, "R8 array kept", rd_data, 8'hC2);
  endtask

  task automatic t_bank();
    int nb;
    bank = 1;
    pulse_ld(8'h00); pulse_wr(8'h42);
    bank = 0;  // bank seen at STOP decides target
    stop_wait(nb);
    bank = 1;
    pulse_ld(8'h00); check(rd_data == 8'hFF, "R11 bank at stop", rd_data, 8'hFF);
    bank = 0; @(negedge clk);
    check(rd_data == 8'h42, "R11 written bank0", rd_data, 8'h42);
    bank = 1;
    pulse_ld(8'h20); pulse_wr(8'h99); stop_wait(nb);
    pulse_ld(8'h20); check(rd_data == 8'h99, "R11 bank1 read", rd_data, 8'h99);
    bank = 0; @(negedge clk);
    check(rd_data == 8'hC0, "R11 bank0 read", rd_data, 8'hC0);
    bank = 1;
    pulse_ld(8'h00); pulse_wr(8'h5B); stop_wait(nb);
    pulse_ld(8'hFF); check(rd_data == 8'hFF, "R3 top of bank", rd_data, 8'hFF);
    pulse_adv(); check(rd_data == 8'h5B, "R3 wrap in bank", rd_data, 8'h5B);
    bank = 0;
  endtask

  task automatic t_inhibit();
    int nb;
    bank = 0; inh = 4'b0010; we_cnt = 0;
    pulse_ld(8'h90); pulse_wr(8'h11);
    stop_wait(nb);
    check(nb == 0 && we_cnt == 0, "R10 inhibited", nb, 0);
    inh = 4'b0000;
    stop_wait(nb);
    check(nb == 0 && we_cnt == 0, "R10 bytes discarded", we_cnt, 0);
    pulse_ld(8'h90); check(rd_data == 8'hFF, "R10 array unchanged", rd_data, 8'hFF);
    pulse_ld(8'h10); pulse_wr(8'h3C); inh = 4'b0010;  // other half still writable
    stop_wait(nb); inh = 4'b0000;
    check(nb == WC, "R10 other half", nb, WC);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_page();
    t_wrap_page();
    t_empty();
    t_busy_ignore();
    t_bank();
    t_inhibit();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule